// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the write side of a network receiver's DMA path. Software places a ring of two-word descriptors in memory. Each descriptor names a receive buffer. The block takes an incoming byte stream and stores each frame into the buffers, one descriptor at a time. After filling a descriptor it records the fill length and frame-boundary flags in that descriptor, then marks the descriptor as owned by hardware.

Software gives a buffer back by clearing the ownership flag. The ring has no length register: a flag in the last descriptor sends the walk back to the ring base address. If a frame finds no free descriptor, the rest of that frame is discarded and an overrun counter advances. Memory is reached through a word-wide master port with byte strobes and a single acknowledge per access.

Top module: `rxr_ring_writer`

## Requirements
- R1: Descriptor word 0 holds the buffer start address in bits 31:2, the ring-end flag in bit 1 and the ownership flag in bit 0. The block fetches word 0 from the current descriptor address and writes frame bytes into the buffer it names.
- R2: The block writes descriptor word 1 (descriptor address + 4) with the byte count in bits 13:0, first-buffer-of-frame in bit 14, last-buffer-of-frame in bit 15, and zero in bits 31:16.
- R3: Descriptors are 8 bytes apart. After a descriptor with the ring-end flag set, the next descriptor is the one at `ring_base`.
- R4: The block fills only a descriptor whose ownership flag is clear. When it finishes with a descriptor, it rewrites word 0 with bit 0 set and all other bits unchanged.
- R5: Each buffer holds `BUF_BYTES` bytes. A longer frame continues in the following descriptors. The first-buffer flag is set only in the first descriptor of a frame and the last-buffer flag only in the final one. A frame that fits in one buffer sets both flags in that descriptor.
- R6: Byte k of a buffer is stored at buffer address + k, on lane k mod 4, little-endian. Only the strobes of bytes actually received are asserted, so bytes past the fill count are left untouched.
- R7: The status word of a descriptor is written before its ownership word.
- R8: If the next descriptor needed is still owned, the block consumes and discards the rest of the frame. The overrun counter advances by one for that frame, and the ring position does not move.
- R9: While `rx_en` is low, the block consumes whole frames that start and discards them with no memory access. Also while `rx_en` is low, the ring position is reloaded from `ring_base` whenever the block is between frames.
- R10: After reset, `in_ready` and `mem_req` are low and the overrun counter is zero.
- R11: A memory request keeps its address and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Input byte accepted this cycle when high with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| overrun_cnt | output | OVR_W | Count of frames cut short by an owned descriptor |

## Verification
The bench targets four things:
- Frames of exactly one buffer, frames that run one byte over a boundary, and a frame that spans the ring-end descriptor. A wrong boundary test would show up as a stray last-buffer flag or a wrong length, and a missed wrap as a write outside the ring.
- The ownership write order. It is checked at the moment ownership is written, so a design that writes ownership first would expose a stale status word.
- An owned descriptor, met both at the start of a frame and in the middle. A design that overwrote it, advanced the ring position or counted per byte would fail the descriptor and counter checks.
- A frame received while disabled. It must cause no memory write and must return the ring position to its base.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int LEN_W     = 14;
    localparam int WORD_B    = 4;
    localparam int DESC_STEP = 8;
    localparam int SOF_BIT   = 14;
    localparam int EOF_BIT   = 15;
    localparam int OWN_BIT   = 0;
    localparam int END_BIT   = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SKIP,
        S_FETCH,
        S_FILL,
        S_FLUSH,
        S_STAT,
        S_OWN,
        S_DROP
    } rx_state_e;

    typedef struct packed {
        logic [29:0] buf_word;
        logic        ring_end;
        logic        owned;
    } desc_head_t;

    function automatic logic [31:0] make_status(logic [LEN_W-1:0] len,
                                                logic first, logic last);
        logic [31:0] w;
        w = '0;
        w[LEN_W-1:0] = len;
        w[SOF_BIT]   = first;
        w[EOF_BIT]   = last;
        return w;
    endfunction

endpackage

// File: rtl/rxr_lane_packer.sv
module rxr_lane_packer #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               push,
    input  logic [LW-1:0]      lane,
    input  logic [7:0]         byte_in,
    output logic [LANES*8-1:0] word,
    output logic [LANES-1:0]   strb
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word[g*8 +: 8] <= '0;
                strb[g]        <= 1'b0;
            end else if (push && lane == LW'(g)) begin
                word[g*8 +: 8] <= byte_in;
                strb[g]        <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr (
    input  logic        clk,
    input  logic        rst,
    input  logic        reload,
    input  logic        advance,
    input  logic        wrap,
    input  logic [31:0] ring_base,
    output logic [31:0] ptr
);
    import rxr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            ptr <= ring_base;
        end else if (advance) begin
            ptr <= wrap ? ring_base : ptr + 32'(DESC_STEP);
        end
    end

    // R3: the ring position stays on a descriptor boundary relative to the base
    property p_ptr_step;
        @(posedge clk) disable iff (rst)
        (advance && !wrap && !reload) |=> (ptr - $past(ptr)) == 32'(DESC_STEP);
    endproperty
    assert_ptr_step_R3: assert property (p_ptr_step);
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
    parameter int BUF_BYTES = 1536,
    parameter int OVR_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic [31:0]      ring_base,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_strb,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic [OVR_W-1:0] overrun_cnt
);
    import rxr_pkg::*;

    localparam logic [LEN_W-1:0] FULL = LEN_W'(BUF_BYTES);

    rx_state_e          state;
    desc_head_t         head;
    logic [LEN_W-1:0]   cnt;
    logic               first_r;
    logic               last_r;
    logic               stat_done;
    logic [31:0]        ptr;
    logic [31:0]        pk_word;
    logic [3:0]         pk_strb;
    logic [LEN_W-1:0]   last_off;
    logic [31:0]        word_off;

    rxr_lane_packer #(.LANES(WORD_B)) i_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (state == S_FLUSH && mem_ack),
        .push    (state == S_FILL && in_valid),
        .lane    (cnt[1:0]),
        .byte_in (in_data),
        .word    (pk_word),
        .strb    (pk_strb)
    );

    rxr_ring_ptr i_ptr (
        .clk       (clk),
        .rst       (rst),
        .reload    (state == S_IDLE && !rx_en),
        .advance   (state == S_OWN && mem_ack),
        .wrap      (head.ring_end),
        .ring_base (ring_base),
        .ptr       (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            head        <= '0;
            cnt         <= '0;
            first_r     <= 1'b0;
            last_r      <= 1'b0;
            stat_done   <= 1'b0;
            overrun_cnt <= '0;
        end else begin
            case (state)
                S_IDLE: if (in_valid) begin
                    if (rx_en) begin
                        state   <= S_FETCH;
                        first_r <= 1'b1;
                        last_r  <= 1'b0;
                    end else begin
                        state <= S_SKIP;
                    end
                end
                S_SKIP: if (in_valid && in_last) state <= S_IDLE;
                S_FETCH: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        state       <= S_DROP;
                        overrun_cnt <= overrun_cnt + 1'b1;
                    end else begin
                        head  <= desc_head_t'(mem_rdata);
                        cnt   <= '0;
                        state <= S_FILL;
                    end
                end
                S_FILL: if (in_valid) begin
                    cnt <= cnt + 1'b1;
                    if (in_last) begin
                        last_r <= 1'b1;
                        state  <= S_FLUSH;
                    end else if (cnt + 1'b1 == FULL || cnt[1:0] == 2'd3) begin
                        state <= S_FLUSH;
                    end
                end
                S_FLUSH: if (mem_ack) begin
                    state <= (last_r || cnt == FULL) ? S_STAT : S_FILL;
                end
                S_STAT: if (mem_ack) begin
                    stat_done <= 1'b1;
                    state     <= S_OWN;
                end
                S_OWN: if (mem_ack) begin
                    stat_done <= 1'b0;
                    first_r   <= 1'b0;
                    state     <= last_r ? S_IDLE : S_FETCH;
                end
                S_DROP: if (in_valid && in_last) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign last_off = cnt - 1'b1;
    assign word_off = 32'({last_off[LEN_W-1:2], 2'b00});

    always_comb begin
        in_ready  = (state == S_SKIP) || (state == S_FILL) || (state == S_DROP);
        mem_req   = 1'b0;
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = '0;
        mem_strb  = 4'hF;
        case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_we   = 1'b0;
                mem_strb = 4'h0;
            end
            S_FLUSH: begin
                mem_req   = 1'b1;
                mem_addr  = {head.buf_word, 2'b00} + word_off;
                mem_wdata = pk_word;
                mem_strb  = pk_strb;
            end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_addr  = ptr + 32'(WORD_B);
                mem_wdata = make_status(cnt, first_r, last_r);
            end
            S_OWN: begin
                mem_req   = 1'b1;
                mem_wdata = {head.buf_word, head.ring_end, 1'b1};
            end
            default: ;
        endcase
    end

    // R7: ownership is only written once the status word has been acknowledged
    property p_status_first;
        @(posedge clk) disable iff (rst)
        (state == S_OWN) |-> stat_done;
    endproperty
    assert_status_first_R7: assert property (p_status_first);

    // R11: a pending request holds address and data until acknowledged
    property p_req_hold;
        @(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata));
    endproperty
    assert_req_hold_R11: assert property (p_req_hold);

    // R5: a buffer never receives more than its capacity
    property p_fill_bound;
        @(posedge clk) disable iff (rst)
        1'b1 |-> (cnt <= FULL);
    endproperty
    assert_fill_bound_R5: assert property (p_fill_bound);

    // R8: the overrun counter moves by at most one per cycle
    property p_ovr_step;
        @(posedge clk) disable iff (rst)
        1'b1 |=> (OVR_W'(overrun_cnt - $past(overrun_cnt)) <= OVR_W'(1));
    endproperty
    assert_ovr_step_R8: assert property (p_ovr_step);

    // R6: every buffer data write carries at least one strobe
    property p_strobe_nonzero;
        @(posedge clk) disable iff (rst)
        (state == S_FLUSH) |-> (mem_strb != 4'h0);
    endproperty
    assert_strobe_nonzero_R6: assert property (p_strobe_nonzero);

endmodule

// File: tb/test_rxr_ring_writer.sv
module test_rxr_ring_writer;
    localparam int BUFB  = 16;
    localparam int NDESC = 3;
    localparam int BASE  = 32'h40;
    localparam int BUF0  = 32'h100;
    localparam int BSTEP = 32'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = BASE;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_strb;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  overrun_cnt;

    always #5 clk = ~clk;

    rxr_ring_writer #(.BUF_BYTES(BUFB), .OVR_W(8)) i_rxr_ring_writer (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_strb(mem_strb), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .overrun_cnt(overrun_cnt)
    );

    typedef struct {
        int idx;
        int len;
        bit first;
        bit last;
        int start;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [256];
    int          checks = 0;
    int          errors = 0;
    int          writes = 0;
    int          ovr_exp = 0;
    int          m_idx = 0;
    bit          m_used [NDESC];
    bit          finished = 1'b0;
    logic [31:0] served_addr = '0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] head_of(int i);
        return (BUF0 + i * BSTEP) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
    endfunction

    function automatic logic [7:0] byte_at(int a);
        return mem[a >> 2][(a % 4) * 8 +: 8];
    endfunction

    // scoreboard monitor: runs when a descriptor ownership word is written
    task automatic on_owner_write(int i, logic [31:0] wdata);
        exp_t e;
        logic [31:0] st;
        if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected ownership write", i, -1);
            return;
        end
        e = exp_q.pop_front();
        check(i == e.idx, "R3", "descriptor index", i, e.idx);
        check(wdata == (head_of(i) | 32'h1), "R4", "ownership word", wdata, head_of(i) | 32'h1);
        st = {16'h0, e.last, e.first, 14'(e.len)};
        // R7: status must already be in memory when ownership is written
        check(mem[(BASE + 8 * i + 4) >> 2] == st, "R2", "status word (R7 order)",
              mem[(BASE + 8 * i + 4) >> 2], st);
        for (int k = 0; k < e.len; k++) begin
            if (byte_at(BUF0 + i * BSTEP + k) != 8'(e.start + k))
                check(1'b0, "R1", "buffer byte", byte_at(BUF0 + i * BSTEP + k), 8'(e.start + k));
        end
        check(1'b1, "R6", "buffer bytes", 0, 0);
        if (e.len < BUFB)
            check(byte_at(BUF0 + i * BSTEP + e.len) == 8'hEE, "R6", "byte past fill untouched",
                  byte_at(BUF0 + i * BSTEP + e.len), 8'hEE);
    endtask

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (mem_req && mem_ack)
            check(mem_addr == served_addr, "R11", "address held through ack", mem_addr, served_addr);
        if (mem_req && !mem_ack) begin
            served_addr = mem_addr;
            if (mem_we) begin
                writes++;
                for (int i = 0; i < NDESC; i++)
                    if (mem_addr == BASE + 8 * i && mem_wdata[0]) on_owner_write(i, mem_wdata);
                for (int l = 0; l < 4; l++)
                    if (mem_strb[l]) mem[mem_addr[9:2]][l * 8 +: 8] = mem_wdata[l * 8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
            end
            mem_ack <= 1'b1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic release_desc(int i);
        mem[(BASE + 8 * i) >> 2]     = head_of(i);
        mem[(BASE + 8 * i + 4) >> 2] = 32'h0;
        for (int w = 0; w < BSTEP / 4; w++) mem[(BUF0 + i * BSTEP) / 4 + w] = 32'hEEEE_EEEE;
        m_used[i] = 1'b0;
    endtask

    // driver: predicts descriptor results, then streams the bytes
    task automatic send_frame(int len, int start);
        int pos = 0;
        bit first = 1'b1;
        if (rx_en) begin
            while (pos < len) begin
                int n;
                exp_t e;
                if (m_used[m_idx]) begin
                    ovr_exp++;
                    break;
                end
                n = (len - pos > BUFB) ? BUFB : len - pos;
                e.idx = m_idx; e.len = n; e.first = first;
                e.last = (pos + n == len); e.start = start + pos;
                exp_q.push_back(e);
                m_used[m_idx] = 1'b1;
                m_idx = (m_idx + 1) % NDESC;
                pos += n;
                first = 1'b0;
            end
        end
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = 8'(start + k);
            in_last  = (k == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all predicted descriptors written", exp_q.size(), 0);
    endtask

    initial begin
        int wsnap;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        for (int i = 0; i < NDESC; i++) release_desc(i);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R10", "in_ready after reset", in_ready, 0);
        check(mem_req == 1'b0, "R10", "mem_req after reset", mem_req, 0);
        check(overrun_cnt == 8'd0, "R10", "overrun after reset", overrun_cnt, 0);
        rst = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
        send_frame(5, 8'h10);            // R5 single buffer, partial word
        send_frame(16, 8'h30);           // R5 exactly one buffer
        release_desc(0); release_desc(1);
        send_frame(20, 8'h50);           // R3 spans ring-end descriptor
        send_frame(40, 8'h80);           // R8 owned descriptor mid-frame
        check(overrun_cnt == 8'(ovr_exp), "R8", "overrun after mid-frame stop", overrun_cnt, ovr_exp);
        send_frame(3, 8'hA0);            // R8 owned descriptor at frame start
        check(overrun_cnt == 8'd2, "R8", "overrun after whole-frame drop", overrun_cnt, 2);
        for (int i = 0; i < NDESC; i++) release_desc(i);
        send_frame(7, 8'hC0);            // R8 position held: lands in descriptor 2
        rx_en = 1'b0;
        m_idx = 0;
        repeat (3) @(negedge clk);
        wsnap = writes;
        send_frame(6, 8'hD0);            // R9 disabled frame
        check(writes == wsnap, "R9", "no memory writes while disabled", writes, wsnap);
        check(overrun_cnt == 8'd2, "R9", "overrun unchanged while disabled", overrun_cnt, 2);
        rx_en = 1'b1;
        for (int i = 0; i < NDESC; i++) release_desc(i);
        @(negedge clk);
        send_frame(33, 8'hE0);           // R9 restart at base, R5 three buffers
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule